// File: doc/BRIEF.md
# Page Table Walker

This block refills a translation cache in hardware. When a lookup misses, the cache hands the walker the missing page number and whether the access was a write. The walker then fetches the matching 32-bit entry from a flat, single-level table in memory, checks it, and returns the frame number and permission bits as a refill. When the entry cannot be used, it raises a fault instead. Software does not take part in the walk. The table's location and size come from a base register and a length register. Software can write and read both registers, so it can save and restore them when it switches address spaces.

Each entry takes four bytes, and the walker looks for it at `base + page*4`. A page number at or past the length value faults at once and touches no memory. A fetched entry must be marked present, and a write needs the entry's write permission. When the checks pass, the walker sets the referenced flag, and on a write it also sets the dirty flag. If that changes the word, the walker writes the word back to the same address before it reports the refill. The walker handles one miss at a time and shows it is busy while a walk is in progress.

Top module: `pt_walker`

## Requirements
- R1: During and right after an active-low synchronous reset, `miss_busy`, `mem_req`, `fill_valid` and `fault_valid` are low, and both configuration registers read back as zero.
- R2: A configuration write with `cfg_sel`=0 loads the 32-bit table base. With `cfg_sel`=1 it loads the 12-bit entry count from `cfg_wdata[11:0]`. `cfg_rdata` returns the register selected by `cfg_sel`, zero-extended.
- R3: The entry read goes to address `base + page*4`. `mem_req`, `mem_we` and `mem_addr` stay steady until `mem_ack` is sampled high, with any number of wait cycles in between.
- R4: A page number greater than or equal to the entry count gives `fault_code`=1 (out of bounds) with no memory request.
- R5: An entry with bit 0 (present) clear gives `fault_code`=2 (not present) on both reads and writes, with no write-back. This check comes before the permission check.
- R6: A write miss on a present entry with bit 1 (write permitted) clear gives `fault_code`=3 (protection), with no refill and no write-back.
- R7: On a refill, the walker sets bit 2 (referenced), and on a write miss also bit 3 (dirty). All other bits are kept, including the spare bits 12..4. If the word changed, it is written once to the address it was read from, before the refill is reported. If it did not change, no write takes place.
- R8: A refill reports the missed page on `fill_page`, entry bits 31..13 on `fill_frame`, bit 1 on `fill_writable`, and the updated bit 3 on `fill_dirty`.
- R9: While `miss_busy` is high, `miss_valid` is ignored. A request raised during a walk neither changes the walk in progress nor starts another one.
- R10: Each accepted miss ends with exactly one single-cycle pulse, either `fill_valid` or `fault_valid`. In the next cycle `miss_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | A translation miss is presented |
| miss_page | input | 11 | Missed page number |
| miss_write | input | 1 | The missed access was a write |
| miss_busy | output | 1 | A walk is in progress; requests are ignored |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | 0 selects the table base, 1 selects the entry count |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected configuration register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | The request is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry to write back |
| mem_ack | input | 1 | Memory has completed the request |
| mem_rdata | input | 32 | Entry read data, valid with `mem_ack` |
| fill_valid | output | 1 | Refill result pulse |
| fill_page | output | 11 | Page the refill belongs to |
| fill_frame | output | 19 | Frame number |
| fill_writable | output | 1 | Write permission of the page |
| fill_dirty | output | 1 | Dirty flag after update |
| fault_valid | output | 1 | Fault result pulse |
| fault_code | output | 2 | 1 out of bounds, 2 not present, 3 protection |

## Verification
The bench targets the edge of the table: the last legal page must be walked, while the first page past the limit must fault with no memory cycle. A design with an off-by-one compare would either fetch past the table or refuse its last entry. It also feeds entries that are both absent and read-only to a write miss. A design that checked permission first would report a protection fault for a page that is not even present. Entries whose flags are already set must produce no write-back, and entries with spare bits set must come back intact. A design that always wrote back, or that rebuilt the word field by field, would show up in the write count or the written data. Finally, a second request is raised during a slow memory read, which would catch a walker that re-latched its page while busy.

// File: rtl/pt_walker_pkg.sv
// Shared types and entry field positions for the page table walker.
// Assumes 32-bit entries with the frame number in the upper bits.
package pt_walker_pkg;
    localparam int PTE_W     = 32;
    localparam int FRAME_LSB = 13;
    localparam int BIT_PRES  = 0;
    localparam int BIT_WPERM = 1;
    localparam int BIT_REF   = 2;
    localparam int BIT_DIRTY = 3;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_BOUNDS = 2'd1,
        FLT_ABSENT = 2'd2,
        FLT_PROT   = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WBACK = 2'd2,
        ST_DONE  = 2'd3
    } walk_state_e;
endpackage

// File: rtl/pt_cfg_regs.sv
// Table base and entry-count registers, writable and readable by software.
// Assumes single-cycle writes; reads are combinational on the select.
module pt_cfg_regs #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] rdata,
    output logic [ADDR_W-1:0] base_o,
    output logic [LEN_W-1:0]  count_o
);
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  count_q;

    // Load the register chosen by sel on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            count_q <= '0;
        end else if (wr_en) begin
            if (sel) count_q <= wdata[LEN_W-1:0];
            else     base_q  <= wdata;
        end
    end

    // Return the selected register, zero-extended.
    always_comb begin
        rdata = sel ? {{(ADDR_W-LEN_W){1'b0}}, count_q} : base_q;
    end

    assign base_o  = base_q;
    assign count_o = count_q;

    // R2
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel) |=> (count_o == $past(wdata[LEN_W-1:0])));
endmodule

// File: rtl/pt_entry_check.sv
// Decodes a fetched entry: present and permission checks, flag update,
// and whether a write-back is needed. Purely combinational.
module pt_entry_check
    import pt_walker_pkg::*;
(
    input  logic [PTE_W-1:0] pte_i,
    input  logic             is_write,
    output fault_e           fault_o,
    output logic [PTE_W-1:0] pte_new_o,
    output logic             need_wb_o
);
    logic [PTE_W-1:0] set_mask;

    // Build the flag-set mask for this access type.
    always_comb begin
        set_mask = '0;
        set_mask[BIT_REF]   = 1'b1;
        set_mask[BIT_DIRTY] = is_write;
    end

    // Presence is checked before permission; the update keeps all other bits.
    always_comb begin
        if (!pte_i[BIT_PRES])                    fault_o = FLT_ABSENT;
        else if (is_write && !pte_i[BIT_WPERM])  fault_o = FLT_PROT;
        else                                     fault_o = FLT_NONE;
        pte_new_o = pte_i | set_mask;
        need_wb_o = (fault_o == FLT_NONE) && (pte_new_o != pte_i);
    end
endmodule

// File: rtl/pt_walker.sv
// Single-level page table walker. It takes one miss at a time, checks the page
// against the entry count, reads the entry, checks it, writes updated flags
// back when they change, then pulses a refill or a fault.
// Assumes the memory holds mem_ack high for one cycle per completed request.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int PAGE_W = 11,
    parameter int ADDR_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      miss_valid,
    input  logic [PAGE_W-1:0]         miss_page,
    input  logic                      miss_write,
    output logic                      miss_busy,
    input  logic                      cfg_wr_en,
    input  logic                      cfg_sel,
    input  logic [ADDR_W-1:0]         cfg_wdata,
    output logic [ADDR_W-1:0]         cfg_rdata,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [31:0]               mem_wdata,
    input  logic                      mem_ack,
    input  logic [31:0]               mem_rdata,
    output logic                      fill_valid,
    output logic [PAGE_W-1:0]         fill_page,
    output logic [31-FRAME_LSB:0]     fill_frame,
    output logic                      fill_writable,
    output logic                      fill_dirty,
    output logic                      fault_valid,
    output logic [1:0]                fault_code
);
    localparam int LEN_W   = PAGE_W + 1;
    localparam int FRAME_W = PTE_W - FRAME_LSB;

    logic [ADDR_W-1:0] tbl_base;
    logic [LEN_W-1:0]  tbl_count;
    walk_state_e       state_q;
    logic [PAGE_W-1:0] page_q;
    logic              write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [PTE_W-1:0]  pte_q;
    fault_e            code_q;
    fault_e            chk_fault;
    logic [PTE_W-1:0]  chk_pte;
    logic              chk_wb;
    logic [ADDR_W-1:0] entry_addr;
    logic              out_of_range;

    pt_cfg_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .sel(cfg_sel),
        .wdata(cfg_wdata), .rdata(cfg_rdata),
        .base_o(tbl_base), .count_o(tbl_count)
    );

    pt_entry_check chk_i (
        .pte_i(mem_rdata), .is_write(write_q),
        .fault_o(chk_fault), .pte_new_o(chk_pte), .need_wb_o(chk_wb)
    );

    // Entry address and bounds test for the incoming miss.
    always_comb begin
        entry_addr   = tbl_base + {{(ADDR_W-PAGE_W-2){1'b0}}, miss_page, 2'b00};
        out_of_range = {1'b0, miss_page} >= tbl_count;
    end

    // Walk sequencer: accept, read, optional write-back, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            page_q  <= '0;
            write_q <= 1'b0;
            addr_q  <= '0;
            pte_q   <= '0;
            code_q  <= FLT_NONE;
        end else begin
            case (state_q)
                ST_IDLE: if (miss_valid) begin
                    page_q  <= miss_page;
                    write_q <= miss_write;
                    addr_q  <= entry_addr;
                    pte_q   <= '0;
                    if (out_of_range) begin
                        code_q  <= FLT_BOUNDS;
                        state_q <= ST_DONE;
                    end else begin
                        code_q  <= FLT_NONE;
                        state_q <= ST_READ;
                    end
                end
                ST_READ: if (mem_ack) begin
                    pte_q  <= chk_pte;
                    code_q <= chk_fault;
                    state_q <= chk_wb ? ST_WBACK : ST_DONE;
                end
                ST_WBACK: if (mem_ack) state_q <= ST_DONE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory port and the result pulses from the walk state.
    always_comb begin
        miss_busy     = (state_q != ST_IDLE);
        mem_req       = (state_q == ST_READ) || (state_q == ST_WBACK);
        mem_we        = (state_q == ST_WBACK);
        mem_addr      = addr_q;
        mem_wdata     = pte_q;
        fill_valid    = (state_q == ST_DONE) && (code_q == FLT_NONE);
        fault_valid   = (state_q == ST_DONE) && (code_q != FLT_NONE);
        fault_code    = code_q;
        fill_page     = page_q;
        fill_frame    = pte_q[PTE_W-1 -: FRAME_W];
        fill_writable = pte_q[BIT_WPERM];
        fill_dirty    = pte_q[BIT_DIRTY];
    end

    // R3
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4
    bounds_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && fault_code == 2'd1) |-> !$past(mem_req));

    // R7
    wb_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[BIT_PRES] && mem_wdata[BIT_REF]));

    // R7
    wb_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> ($past(mem_req) && $stable(mem_addr)));

    // R10
    outcome_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid || fault_valid) |=> (!miss_busy && !fill_valid && !fault_valid));
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb_top;
    typedef struct packed {
        logic [10:0] pg;
        logic        wr;
        logic [31:0] pte;
        logic [3:0]  waits;
        logic [1:0]  code;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{11'd5,    1'b0, 32'h2468A001, 4'd0, 2'd0},
        '{11'd7,    1'b0, 32'h00002005, 4'd2, 2'd0},
        '{11'd9,    1'b1, 32'hFFFFE00F, 4'd1, 2'd0},
        '{11'd10,   1'b1, 32'h00004003, 4'd3, 2'd0},
        '{11'd11,   1'b1, 32'h00006001, 4'd0, 2'd3},
        '{11'd12,   1'b0, 32'h00008006, 4'd1, 2'd2},
        '{11'd13,   1'b1, 32'h00008000, 4'd0, 2'd2},
        '{11'd1023, 1'b0, 32'h0000A001, 4'd9, 2'd0},
        '{11'd1024, 1'b0, 32'h0000A001, 4'd0, 2'd1},
        '{11'd2047, 1'b1, 32'h0000A003, 4'd0, 2'd1},
        '{11'd0,    1'b0, 32'h00011FF1, 4'd2, 2'd0}
    };
    localparam logic [31:0] BASE = 32'h0001_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miss_valid = 1'b0, miss_write = 1'b0, miss_busy;
    logic [10:0] miss_page = '0;
    logic cfg_wr_en = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic fill_valid, fill_writable, fill_dirty, fault_valid;
    logic [10:0] fill_page;
    logic [18:0] fill_frame;
    logic [1:0] fault_code;

    int n_chk = 0;
    int n_err = 0;

    logic        o_fill, o_fault, o_w, o_d, o_busy_mid;
    logic [1:0]  o_code;
    logic [18:0] o_frame;
    logic [10:0] o_page;
    logic [31:0] o_rd_addr, o_wr_addr, o_wdata;
    int          o_reads, o_writes, o_req_cyc;

    always #10 clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_page(miss_page), .miss_write(miss_write),
        .miss_busy(miss_busy),
        .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .fill_valid(fill_valid), .fill_page(fill_page), .fill_frame(fill_frame),
        .fill_writable(fill_writable), .fill_dirty(fill_dirty),
        .fault_valid(fault_valid), .fault_code(fault_code)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // One miss served by a bench memory that acks after 'waits' cycles.
    task automatic run_walk(input logic [10:0] pg, input logic wr, input logic [31:0] pte,
                            input int waits, input logic inject);
        int cnt = 0;
        int cyc = 0;
        logic done = 1'b0;
        o_fill = 0; o_fault = 0; o_code = 0; o_frame = 0; o_page = 0; o_w = 0; o_d = 0;
        o_rd_addr = 0; o_wr_addr = 0; o_wdata = 0; o_reads = 0; o_writes = 0;
        o_req_cyc = 0; o_busy_mid = 0;
        @(negedge clk);
        miss_valid = 1'b1; miss_page = pg; miss_write = wr;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) o_busy_mid = miss_busy;
            if (inject && cyc <= 2) begin
                miss_valid = 1'b1; miss_page = pg + 11'd1; miss_write = ~wr;
            end else begin
                miss_valid = 1'b0;
            end
            mem_ack = 1'b0;
            if (fill_valid || fault_valid) begin
                done = 1'b1;
                o_fill = fill_valid; o_fault = fault_valid; o_code = fault_code;
                o_frame = fill_frame; o_page = fill_page;
                o_w = fill_writable; o_d = fill_dirty;
            end else if (mem_req) begin
                o_req_cyc++;
                if (cnt == waits) begin
                    mem_ack = 1'b1;
                    cnt = 0;
                    if (mem_we) begin
                        o_writes++; o_wdata = mem_wdata; o_wr_addr = mem_addr;
                    end else begin
                        o_reads++; o_rd_addr = mem_addr; mem_rdata = pte;
                    end
                end else begin
                    cnt++;
                end
            end
        end
        miss_valid = 1'b0;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL R10 walk timeout actual=no-result expected=result");
        end
        // R10: pulse lasts one cycle and the walker is idle afterwards
        @(negedge clk);
        check("R10 idle after result", {28'd0, miss_busy, mem_req, fill_valid, fault_valid}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", {28'd0, miss_busy, mem_req, fill_valid, fault_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_sel = 1'b0; #1;
        check("R1 base after reset", cfg_rdata, 32'd0);
        cfg_sel = 1'b1; #1;
        check("R1 count after reset", cfg_rdata, 32'd0);
        check("R1 idle after reset", {30'd0, miss_busy, mem_req}, 32'd0);

        // R4: entry count zero makes page 0 out of bounds
        run_walk(11'd0, 1'b0, 32'h00002001, 0, 1'b0);
        check("R4 zero count fault", {30'd0, o_code}, 32'd1);
        check("R4 zero count no access", o_req_cyc, 32'd0);

        // R2: register write and readback, count keeps only 12 bits
        cfg_write(1'b0, BASE);
        cfg_write(1'b1, 32'hFFFF_F400);
        cfg_sel = 1'b0; #1;
        check("R2 base readback", cfg_rdata, BASE);
        cfg_sel = 1'b1; #1;
        check("R2 count readback", cfg_rdata, 32'h0000_0400);

        // Table-driven walks
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] upd;
            logic        exp_wb;
            upd = VECS[i].pte | 32'h4 | (VECS[i].wr ? 32'h8 : 32'h0);
            exp_wb = (VECS[i].code == 2'd0) && (upd != VECS[i].pte);
            run_walk(VECS[i].pg, VECS[i].wr, VECS[i].pte, int'(VECS[i].waits), 1'b0);
            // R4 R5 R6 R10: outcome kind and code
            check("R10 outcome kind", {30'd0, o_fill, o_fault},
                  (VECS[i].code == 2'd0) ? 32'd2 : 32'd1);
            if (VECS[i].code != 2'd0)
                check("R5 R6 R4 fault code", {30'd0, o_code}, {30'd0, VECS[i].code});
            if (VECS[i].code == 2'd1) begin
                check("R4 no memory access", o_req_cyc, 32'd0);
            end else begin
                check("R3 entry address", o_rd_addr, BASE + {19'd0, VECS[i].pg, 2'b00});
                check("R3 one read", o_reads, 32'd1);
            end
            check("R7 write-back count", o_writes, {31'd0, exp_wb});
            if (exp_wb) begin
                check("R7 write-back data", o_wdata, upd);
                check("R7 write-back address", o_wr_addr, o_rd_addr);
            end
            if (VECS[i].code == 2'd0) begin
                check("R8 frame", {13'd0, o_frame}, {13'd0, VECS[i].pte[31:13]});
                check("R8 page", {21'd0, o_page}, {21'd0, VECS[i].pg});
                check("R8 writable", {31'd0, o_w}, {31'd0, VECS[i].pte[1]});
                check("R8 dirty", {31'd0, o_d}, {31'd0, upd[3]});
            end
        end

        // R9: request raised during a slow read is ignored
        run_walk(11'd20, 1'b0, 32'h0000C005, 3, 1'b1);
        check("R9 busy during walk", {31'd0, o_busy_mid}, 32'd1);
        check("R9 page unchanged", {21'd0, o_page}, 32'd20);
        check("R9 single read", o_reads, 32'd1);
        check("R9 no write from injected write", o_writes, 32'd0);
        repeat (3) begin
            @(negedge clk);
            check("R9 no second walk", {30'd0, mem_req, miss_busy}, 32'd0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule